// File: doc/BRIEF.md
# Performance Counter Overflow and Software Increment Unit

This unit holds three event counters and one cycle counter, each `CNT_W` bits wide (32 by default). Each counter has a sticky overflow flag. An event counter advances on a hardware event line picked by its 8-bit select code. If the select code is 0x00, the counter instead advances on software increments. The cycle counter advances on every clock while it is enabled. Each counter also has its own enable, a zeroing strobe, and the shared global enable.

Software reaches two registers through a simple request port. The overflow-flag register is read, and it is written with ones to clear flags. The increment register is write-only. A request carries a privilege bit. A request made without privilege is served only while the user-enable input is high. Any other request from user mode is refused and raises a one-cycle access-error pulse.

Requests are handled by a four-state access machine. `ACC_IDLE` is the state with no request. `ACC_READ` presents read data, `ACC_WRITE` applies a flag clear or an increment, and `ACC_DENY` signals a refused request. A request sampled at a clock edge selects the state for the next cycle: refused leads to `ACC_DENY`, a permitted write to `ACC_WRITE`, a permitted read to `ACC_READ`, and no request to `ACC_IDLE`. Read data and the error pulse are visible during that cycle. A write changes counters and flags at the edge that ends it.

Top module: `pmu_overflow_unit`

## Requirements
- R1: Reading the flag register (`req_sel`=0) returns the cycle-counter flag in bit 31 and the flags of event counters 0, 1 and 2 in bits 0, 1 and 2. Bits 30..3 read as zero. `rd_valid` is high for exactly the cycle after the request, and `rd_data` is zero whenever `rd_valid` is low.
- R2: A counter that is incremented while holding all ones wraps to zero and sets its overflow flag at the same edge. An increment with the zeroing strobe high does not count as a wrap.
- R3: A set flag stays set until a write to the flag register has a 1 in that flag's bit position. Writing 0 to a flag bit leaves the flag unchanged, and writes to bits 30..3 change nothing.
- R4: Clearing a counter's enable, clearing the global enable, or pulsing a counter's zeroing strobe leaves every overflow flag unchanged.
- R5: When a counter wraps at the same edge that a write-one-to-clear hits its flag, the flag is set after that edge.
- R6: A read of the increment register (`req_sel`=1) returns zero with `rd_valid` high.
- R7: A write to the increment register adds one to event counter i for each set bit i of `req_wdata[2:0]`. This happens only when that counter's select code is 0x00, its enable is high and the global enable is high.
- R8: A request is permitted when `req_priv` is 1, or when `user_en` is 1. A refused request changes no counter or flag and gives `rd_valid`=0 and `rd_data`=0. It raises `acc_err` for exactly the cycle after the request.
- R9: An event counter whose select code s is nonzero and below `EVT_LINES` increments at each edge where `evt_lines[s]`, its enable and the global enable are all high. A code of `EVT_LINES` or more never counts.
- R10: The cycle counter increments at every edge where `ctr_en[3]` and the global enable are high. Any counter's zeroing strobe forces its value to zero at the next edge, and takes priority over an increment.
- R11: After reset all counters and flags are zero, and `rd_valid` and `acc_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glb_en | input | 1 | Global counting enable |
| ctr_en | input | NUM_EVT+1 | Per-counter enables; the top bit is the cycle counter |
| ctr_clr | input | NUM_EVT+1 | Per-counter zeroing strobes; the top bit is the cycle counter |
| evt_sel | input | NUM_EVT*8 | Event select code of each event counter, counter i at bits [8i+7:8i] |
| evt_lines | input | EVT_LINES | Hardware event lines |
| req_valid | input | 1 | Register request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = flag register, 1 = increment register |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | 1 = privileged request |
| user_en | input | 1 | Permits requests without privilege |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | One-cycle pulse for a refused request |
| evt_count | output | NUM_EVT*CNT_W | Event counter values, counter i at bits [CNT_W*i+CNT_W-1:CNT_W*i] |
| cyc_count | output | CNT_W | Cycle counter value |

## Verification
Suppose a flag bit is lost or set when it should not be. The next flag-register read exposes it, one cycle after that read request. Suppose instead the access machine lands in the wrong state. Then `rd_valid` or `acc_err` is wrong in the very next cycle, or a counter value shows a stray or missing software increment one edge later. A select or enable that is decoded wrongly shows up as a wrong counter value after the first edge with an event. The bench therefore compares every counter value, `rd_valid`, `rd_data` and `acc_err` after every edge.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int REG_W        = 32;
    localparam int CYC_FLAG_POS = 31;
    localparam int SEL_W        = 8;
    localparam logic [SEL_W-1:0] SW_COUNT_CODE = 8'h00;
    localparam logic REG_FLAGS  = 1'b0;
    localparam logic REG_SWINC  = 1'b1;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE,
        ACC_DENY
    } acc_state_e;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] value_o,
    output logic         wrap_o
);
    logic [W-1:0] value_q;
    logic         at_max;

    assign at_max  = &value_q;
    assign wrap_o  = inc_i & ~clr_i & at_max;
    assign value_o = value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      value_q <= '0;
        else if (clr_i)  value_q <= '0;
        else if (inc_i)  value_q <= value_q + 1'b1;
    end

    p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && at_max) |=> (value_q == '0));

    p_strobe_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (value_q == '0));

    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(value_q));
endmodule

// File: rtl/pmu_flag_bank.sv
module pmu_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wrap_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | wrap_i;
    end

    assign flags_o = flags_q;

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i)));

    p_wrap_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i != '0) |=> ((flags_q & $past(wrap_i)) == $past(wrap_i)));

    p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(wrap_i)) == '0));
endmodule

// File: rtl/pmu_access_fsm.sv
module pmu_access_fsm
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic               req_sel_i,
    input  logic [REG_W-1:0]   req_wdata_i,
    input  logic               req_priv_i,
    input  logic               user_en_i,
    input  logic [NUM_EVT:0]   flags_i,
    output logic               rd_valid_o,
    output logic [REG_W-1:0]   rd_data_o,
    output logic               acc_err_o,
    output logic [NUM_EVT:0]   flag_clr_o,
    output logic [NUM_EVT-1:0] sw_inc_o
);
    acc_state_e         state_q, state_d;
    logic               sel_q;
    logic [NUM_EVT:0]   wmask_q;
    logic               permitted;
    logic [REG_W-1:0]   flag_word;

    assign permitted = req_priv_i | user_en_i;

    // next-state selection
    always_comb begin
        state_d = ACC_IDLE;
        if (req_valid_i) begin
            if (!permitted)       state_d = ACC_DENY;
            else if (req_write_i) state_d = ACC_WRITE;
            else                  state_d = ACC_READ;
        end
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            sel_q   <= REG_FLAGS;
            wmask_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid_i) begin
                sel_q   <= req_sel_i;
                wmask_q <= {req_wdata_i[CYC_FLAG_POS], req_wdata_i[NUM_EVT-1:0]};
            end
        end
    end

    // flag register layout
    always_comb begin
        flag_word = '0;
        flag_word[CYC_FLAG_POS] = flags_i[NUM_EVT];
        for (int i = 0; i < NUM_EVT; i++) begin
            flag_word[i] = flags_i[i];
        end
    end

    // outputs per state
    always_comb begin
        rd_valid_o = 1'b0;
        rd_data_o  = '0;
        acc_err_o  = 1'b0;
        flag_clr_o = '0;
        sw_inc_o   = '0;
        unique case (state_q)
            ACC_IDLE: ;
            ACC_READ: begin
                rd_valid_o = 1'b1;
                rd_data_o  = (sel_q == REG_FLAGS) ? flag_word : '0;
            end
            ACC_WRITE: begin
                if (sel_q == REG_FLAGS) flag_clr_o = wmask_q;
                else                    sw_inc_o   = wmask_q[NUM_EVT-1:0];
            end
            ACC_DENY: acc_err_o = 1'b1;
            default: ;
        endcase
    end

    p_blocked_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_priv_i && !user_en_i) |=> (acc_err_o && !rd_valid_o));

    p_deny_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err_o |-> (flag_clr_o == '0 && sw_inc_o == '0 && rd_data_o == '0));

    p_err_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err_o && !$past(req_valid_i && !permitted)) |-> 1'b0);

    p_swinc_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && permitted && !req_write_i && req_sel_i == REG_SWINC)
            |=> (rd_valid_o && rd_data_o == '0));

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rd_data_o[CYC_FLAG_POS-1:NUM_EVT] == '0));
endmodule

// File: rtl/pmu_overflow_unit.sv
module pmu_overflow_unit
    import pmu_pkg::*;
#(
    parameter int NUM_EVT   = 3,
    parameter int CNT_W     = 32,
    parameter int EVT_LINES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     glb_en,
    input  logic [NUM_EVT:0]         ctr_en,
    input  logic [NUM_EVT:0]         ctr_clr,
    input  logic [NUM_EVT*SEL_W-1:0] evt_sel,
    input  logic [EVT_LINES-1:0]     evt_lines,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic                     req_sel,
    input  logic [REG_W-1:0]         req_wdata,
    input  logic                     req_priv,
    input  logic                     user_en,
    output logic                     rd_valid,
    output logic [REG_W-1:0]         rd_data,
    output logic                     acc_err,
    output logic [NUM_EVT*CNT_W-1:0] evt_count,
    output logic [CNT_W-1:0]         cyc_count
);
    localparam int LINE_IDX_W = (EVT_LINES > 1) ? $clog2(EVT_LINES) : 1;
    localparam int NUM_CTR    = NUM_EVT + 1;

    logic [NUM_CTR-1:0] wrap;
    logic [NUM_CTR-1:0] flags;
    logic [NUM_CTR-1:0] flag_clr;
    logic [NUM_EVT-1:0] sw_inc;
    logic [NUM_CTR-1:0] inc;

    pmu_access_fsm #(.NUM_EVT(NUM_EVT)) u_access (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_sel_i   (req_sel),
        .req_wdata_i (req_wdata),
        .req_priv_i  (req_priv),
        .user_en_i   (user_en),
        .flags_i     (flags),
        .rd_valid_o  (rd_valid),
        .rd_data_o   (rd_data),
        .acc_err_o   (acc_err),
        .flag_clr_o  (flag_clr),
        .sw_inc_o    (sw_inc)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        logic [SEL_W-1:0] sel;
        logic             is_sw;
        logic             hw_hit;

        assign sel    = evt_sel[g*SEL_W +: SEL_W];
        assign is_sw  = (sel == SW_COUNT_CODE);
        assign hw_hit = !is_sw && (sel < SEL_W'(EVT_LINES))
                        && evt_lines[sel[LINE_IDX_W-1:0]];
        assign inc[g] = glb_en & ctr_en[g] & (is_sw ? sw_inc[g] : hw_hit);

        pmu_counter #(.W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (inc[g]),
            .clr_i   (ctr_clr[g]),
            .value_o (evt_count[g*CNT_W +: CNT_W]),
            .wrap_o  (wrap[g])
        );

        p_swinc_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_inc[g] && is_sw && glb_en && ctr_en[g] && !ctr_clr[g]
                && evt_count[g*CNT_W +: CNT_W] != '1)
            |=> (evt_count[g*CNT_W +: CNT_W]
                 == $past(evt_count[g*CNT_W +: CNT_W]) + 1'b1));
    end

    assign inc[NUM_EVT] = glb_en & ctr_en[NUM_EVT];

    pmu_counter #(.W(CNT_W)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (inc[NUM_EVT]),
        .clr_i   (ctr_clr[NUM_EVT]),
        .value_o (cyc_count),
        .wrap_o  (wrap[NUM_EVT])
    );

    pmu_flag_bank #(.N(NUM_CTR)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_i  (wrap),
        .clr_i   (flag_clr),
        .flags_o (flags)
    );

    p_gated_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !ctr_clr[NUM_EVT]) |=> $stable(cyc_count));
endmodule

// File: tb/pmu_overflow_unit_test.sv
`timescale 1ns/1ps
module pmu_overflow_unit_test;
    localparam int NE = 3;
    localparam int CW = 8;
    localparam int NL = 16;
    localparam int MAXV = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            glb_en = 1'b0;
    logic [NE:0]     ctr_en = '0;
    logic [NE:0]     ctr_clr = '0;
    logic [NE*8-1:0] evt_sel = '0;
    logic [NL-1:0]   evt_lines = '0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic            req_sel = 1'b0;
    logic [31:0]     req_wdata = '0;
    logic            req_priv = 1'b1;
    logic            user_en = 1'b0;
    logic            rd_valid;
    logic [31:0]     rd_data;
    logic            acc_err;
    logic [NE*CW-1:0] evt_count;
    logic [CW-1:0]   cyc_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int unsigned m_cnt [NE+1];
    bit          m_flag[NE+1];
    bit [NE:0]   pend_clr;
    bit [NE-1:0] pend_inc;
    bit          exp_err, exp_rdv;
    logic [31:0] exp_rd;

    pmu_overflow_unit #(.NUM_EVT(NE), .CNT_W(CW), .EVT_LINES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ctr_en(ctr_en),
        .ctr_clr(ctr_clr), .evt_sel(evt_sel), .evt_lines(evt_lines),
        .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
        .req_wdata(req_wdata), .req_priv(req_priv), .user_en(user_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
        .evt_count(evt_count), .cyc_count(cyc_count)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] flag_word();
        return {m_flag[NE], 28'b0, m_flag[2], m_flag[1], m_flag[0]};
    endfunction

    function automatic logic [CW-1:0] cnt_of(input int i);
        return evt_count[i*CW +: CW];
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        bit allowed;
        for (int i = 0; i <= NE; i++) begin
            bit incv, wrapv;
            int unsigned s;
            if (i < NE) begin
                s = evt_sel[i*8 +: 8];
                incv = glb_en && ctr_en[i] &&
                       ((s == 0) ? pend_inc[i] : (s < NL && evt_lines[s]));
            end else begin
                incv = glb_en && ctr_en[NE];
            end
            wrapv = incv && !ctr_clr[i] && (m_cnt[i] == MAXV);
            if (ctr_clr[i])  m_cnt[i] = 0;
            else if (incv)   m_cnt[i] = (m_cnt[i] + 1) & MAXV;
            m_flag[i] = (m_flag[i] && !pend_clr[i]) || wrapv;
        end
        allowed  = req_priv || user_en;
        pend_clr = '0;
        pend_inc = '0;
        exp_err  = req_valid && !allowed;
        exp_rdv  = req_valid && allowed && !req_write;
        if (req_valid && allowed && req_write) begin
            if (req_sel) pend_inc = req_wdata[NE-1:0];
            else         pend_clr = {req_wdata[31], req_wdata[NE-1:0]};
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        exp_rd = (exp_rdv && !req_sel_last) ? flag_word() : 32'h0;
        for (int i = 0; i < NE; i++)
            check(cnt_of(i) == CW'(m_cnt[i]), "R9 event counter value", 32'(cnt_of(i)), m_cnt[i]);
        check(cyc_count == CW'(m_cnt[NE]), "R10 cycle counter value", 32'(cyc_count), m_cnt[NE]);
        check(acc_err == exp_err, "R8 access error", 32'(acc_err), 32'(exp_err));
        check(rd_valid == exp_rdv, "R1 read valid", 32'(rd_valid), 32'(exp_rdv));
        check(rd_data == exp_rd, "R1 read data", rd_data, exp_rd);
    endtask

    logic req_sel_last = 1'b0;
    always @(posedge clk) req_sel_last <= req_sel;

    task automatic do_req(input bit w, input bit s, input logic [31:0] d);
        req_valid = 1'b1; req_write = w; req_sel = s; req_wdata = d;
        step();
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic set_sel(input int i, input logic [7:0] code);
        evt_sel[i*8 +: 8] = code;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i <= NE; i++) begin m_cnt[i] = 0; m_flag[i] = 0; end
        pend_clr = '0; pend_inc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(evt_count == '0, "R11 counters after reset", 32'(evt_count), 0);
        check(cyc_count == '0, "R11 cycle counter after reset", 32'(cyc_count), 0);
        check(!rd_valid && !acc_err, "R11 outputs after reset", {rd_valid, acc_err}, 0);
        do_req(1'b0, 1'b0, 0);
        check(rd_valid && rd_data == 0, "R11 flags after reset", rd_data, 0);

        // R10 cycle counter and zeroing strobe
        glb_en = 1'b1; ctr_en[NE] = 1'b1;
        repeat (10) step();
        check(cyc_count == 8'd10, "R10 cycle count after 10 edges", 32'(cyc_count), 10);
        ctr_clr[NE] = 1'b1; step(); ctr_clr[NE] = 1'b0;
        check(cyc_count == 0, "R10 zeroing strobe", 32'(cyc_count), 0);

        // R9 hardware events
        set_sel(0, 8'd5); ctr_en[0] = 1'b1;
        evt_lines[5] = 1'b1; repeat (3) step(); evt_lines[5] = 1'b0;
        evt_lines[4] = 1'b1; repeat (2) step(); evt_lines[4] = 1'b0;
        check(cnt_of(0) == 3, "R9 only selected line counts", 32'(cnt_of(0)), 3);
        set_sel(0, 8'd20); evt_lines = '1; repeat (2) step(); evt_lines = '0;
        check(cnt_of(0) == 3, "R9 out-of-range code never counts", 32'(cnt_of(0)), 3);
        set_sel(0, 8'd5);

        // R2 wrap
        set_sel(2, 8'd7); ctr_en[2] = 1'b1;
        evt_lines[7] = 1'b1; repeat (MAXV) step(); evt_lines[7] = 1'b0;
        do_req(1'b0, 1'b0, 0);
        check(cnt_of(2) == MAXV && rd_data[2] == 1'b0, "R2 no flag before wrap", rd_data, 0);
        evt_lines[7] = 1'b1; step(); evt_lines[7] = 1'b0;
        check(cnt_of(2) == 0, "R2 wraps to zero", 32'(cnt_of(2)), 0);
        do_req(1'b0, 1'b0, 0);
        check(rd_data[2] && rd_data[30:3] == 0, "R1 R2 flag at bit 2", rd_data, 32'h4 | (rd_data & 32'h8000_0000));

        // R3 sticky, write-zero and reserved bits ignored
        do_req(1'b1, 1'b0, 32'h0); step();
        do_req(1'b1, 1'b0, 32'h7FFF_FFF8); step();
        do_req(1'b0, 1'b0, 0);
        check(rd_data[2], "R3 flag survives zero and reserved writes", rd_data, 32'h4);
        do_req(1'b1, 1'b0, 32'h4); step();
        do_req(1'b0, 1'b0, 0);
        check(!rd_data[2], "R3 write one clears", rd_data, 0);

        // R4 flag survives disables and strobe
        evt_lines[7] = 1'b1; repeat (MAXV + 1) step(); evt_lines[7] = 1'b0;
        ctr_en[2] = 1'b0; step();
        glb_en = 1'b0; step();
        ctr_clr[2] = 1'b1; step(); ctr_clr[2] = 1'b0;
        do_req(1'b0, 1'b0, 0);
        check(rd_data[2] && cnt_of(2) == 0, "R4 flag kept after disable and strobe", rd_data, 32'h4);
        glb_en = 1'b1; ctr_en[2] = 1'b1;

        // R5 wrap and clear on the same edge
        evt_lines[7] = 1'b1; repeat (MAXV) step(); evt_lines[7] = 1'b0;
        do_req(1'b1, 1'b0, 32'h4);
        evt_lines[7] = 1'b1; step(); evt_lines[7] = 1'b0;
        do_req(1'b0, 1'b0, 0);
        check(rd_data[2] && cnt_of(2) == 0, "R5 wrap wins over clear", rd_data, 32'h4);

        // R6 increment register reads zero
        do_req(1'b0, 1'b1, 0);
        check(rd_valid && rd_data == 0, "R6 increment register read", rd_data, 0);

        // R7 software increment gating
        set_sel(1, 8'h00); ctr_en[1] = 1'b1;
        do_req(1'b1, 1'b1, 32'h2); step();
        check(cnt_of(1) == 1, "R7 software increment applies", 32'(cnt_of(1)), 1);
        do_req(1'b1, 1'b1, 32'h1); step();
        check(cnt_of(0) == 3, "R7 nonzero select ignores increment", 32'(cnt_of(0)), 3);
        ctr_en[1] = 1'b0;
        do_req(1'b1, 1'b1, 32'h2); step();
        check(cnt_of(1) == 1, "R7 disabled counter ignores increment", 32'(cnt_of(1)), 1);
        ctr_en[1] = 1'b1;

        // R8 user-mode gating
        req_priv = 1'b0; user_en = 1'b0;
        do_req(1'b1, 1'b1, 32'h2);
        check(acc_err, "R8 blocked write raises error", 32'(acc_err), 1);
        step();
        check(!acc_err && cnt_of(1) == 1, "R8 error one cycle and no effect", {acc_err, cnt_of(1)}, 1);
        do_req(1'b0, 1'b0, 0);
        check(!rd_valid && rd_data == 0 && acc_err, "R8 blocked read returns zero", rd_data, 0);
        user_en = 1'b1;
        do_req(1'b1, 1'b1, 32'h2); step();
        check(cnt_of(1) == 2 && !acc_err, "R8 user access when enabled", 32'(cnt_of(1)), 2);
        req_priv = 1'b1; user_en = 1'b0;

        // random mix
        for (int it = 0; it < 1500; it++) begin
            logic [7:0] codes [4];
            codes[0] = 8'd0; codes[1] = 8'd3; codes[2] = 8'd9; codes[3] = 8'd20;
            for (int i = 0; i < NE; i++) set_sel(i, codes[$urandom_range(0, 3)]);
            evt_lines = NL'($urandom);
            ctr_en    = (NE+1)'($urandom) | (NE+1)'($urandom);
            glb_en    = ($urandom_range(0, 7) != 0);
            ctr_clr   = ($urandom_range(0, 31) == 0) ? (NE+1)'($urandom) : '0;
            req_valid = ($urandom_range(0, 2) == 0);
            req_write = $urandom_range(0, 1);
            req_sel   = $urandom_range(0, 1);
            req_wdata = $urandom;
            req_priv  = ($urandom_range(0, 3) != 0);
            user_en   = $urandom_range(0, 1);
            step();
        end
        req_valid = 1'b0; ctr_clr = '0; req_priv = 1'b1;
        step();
        do_req(1'b0, 1'b0, 0);
        exp_rd = flag_word();
        check(rd_data == exp_rd, "R3 flags after random run", rd_data, exp_rd);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule